// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block keeps a table of two-bit saturating counters, one per slot, selected by the word-address bits of a branch's program counter. On the lookup side, fetch logic presents a PC and receives a taken or not-taken guess in the same cycle. Fetch then uses that guess to choose between the fall-through address and the branch target. On the update side, the resolution stage presents the PC of a resolved branch and its real direction. The selected counter moves one step toward that direction on the next rising clock edge. In the same cycle as the update, the block raises a flag when the stored guess was wrong.

Because each counter has two bits, a single surprise does not reverse the guess; it takes two wrong outcomes in a row. A loop-closing branch therefore costs one miss when the loop exits. Entering the loop again costs no further miss.

Both ports follow valid/ready rules. Each ready output is held high at all times, so the block never applies back-pressure. A lookup or an update is accepted in every cycle in which its valid input is high. When valid is low, the matching outputs are held at zero and the table is left unchanged.

Top module: `bhp_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken). A lookup predicts not-taken, and one taken update is enough to make that slot predict taken.
- R2: The slot is selected by PC bits [IDX_W+1:2]. PCs that differ only in bits [1:0] or in bits above IDX_W+1 share a slot; PCs with different index bits do not affect one another.
- R3: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. The prediction is bit 1 of the counter.
- R4: An accepted update with a taken outcome adds one to the counter, and a counter at 11 stays at 11.
- R5: An accepted update with a not-taken outcome subtracts one from the counter, and a counter at 00 stays at 00.
- R6: When a lookup and an update select the same slot in the same cycle, the lookup returns the prediction from before that update.
- R7: upd_mispredict is high in an update cycle exactly when the stored prediction differs from upd_taken. It is low whenever upd_valid is low.
- R8: lk_taken is low whenever lk_valid is low, and lk_ready and upd_ready are always high.
- R9: While upd_valid is low, no counter changes, whatever values are on upd_pc and upd_taken.
- R10: From 11, one not-taken outcome leaves the prediction taken, so a loop branch misses only on its exit and not on re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted (always high) |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction, same cycle |
| upd_valid | input | 1 | Resolved branch present |
| upd_ready | output | 1 | Update accepted (always high) |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the branch |
| upd_mispredict | output | 1 | Stored guess disagreed with upd_taken |

## Verification
The bench builds the block with IDX_W=3 and PC_W=16, which gives eight slots. With so few slots, aliasing between PCs that are 32 bytes apart can be reached with a handful of addresses. Every slot can be read back after reset, and both saturation limits can be reached in a few updates. Under this setting, same-slot collisions between a lookup and an update are easy to construct on purpose, and the loop exit and re-entry pattern shows its single miss within a short run.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;
endpackage

// File: rtl/bhp_index.sv
module bhp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // word aligned: drop the two byte-offset bits, keep the next IDX_W
  assign idx = IDX_W'(pc >> 2);
endmodule

// File: rtl/bhp_step.sv
module bhp_step
  import bhp_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_SNT) nxt = cur - 2'd1;
    end
  end
endmodule

// File: rtl/bhp_bank.sv
module bhp_bank
  import bhp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr_t             rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr_t             rd_b,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  ctr_t             w_data
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WNT;
    end else if (we) begin
      mem[w_idx] <= w_data;
    end
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R9: a slot that is not written keeps its value
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && w_idx == IDX_W'(g)) |=> $stable(mem[g]));
    end
  endgenerate
endmodule

// File: rtl/bhp_predictor.sv
module bhp_predictor
  import bhp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            upd_mispredict
);
  logic [IDX_W-1:0] lk_idx, upd_idx;
  ctr_t             lk_cur, upd_cur, upd_next;

  bhp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) lk_ix_i  (.pc(lk_pc),  .idx(lk_idx));
  bhp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) upd_ix_i (.pc(upd_pc), .idx(upd_idx));

  bhp_bank #(.IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_idx), .rd_a(lk_cur),
    .rd_b_idx(upd_idx), .rd_b(upd_cur),
    .we(upd_valid), .w_idx(upd_idx), .w_data(upd_next)
  );

  bhp_step step_i (.cur(upd_cur), .taken(upd_taken), .nxt(upd_next));

  assign lk_ready       = 1'b1;
  assign upd_ready      = 1'b1;
  assign lk_taken       = lk_valid & lk_cur[1];
  assign upd_mispredict = upd_valid & (upd_cur[1] ^ upd_taken);

  a_r4_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_cur == CTR_ST) |-> (upd_next == CTR_ST));
  a_r5_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur == CTR_SNT) |-> (upd_next == CTR_SNT));
  a_r10_hyst: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_cur == CTR_ST) |-> upd_next[1]);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !upd_mispredict);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_taken);
endmodule

// File: tb/bhp_predictor_tb_top.sv
module bhp_predictor_tb_top;
  localparam int PC_W  = 16;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, upd_valid = 0, upd_taken = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic lk_ready, lk_taken, upd_ready, upd_mispredict;

  always #5 clk = ~clk;

  bhp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_mispredict(upd_mispredict)
  );

  typedef struct {
    string req;
    bit    exp_lk;
    bit    exp_mp;
  } item_t;

  item_t sb[$];
  int model [DEPTH];
  int errors = 0, checks = 0;

  function automatic int slot(input logic [PC_W-1:0] pc);
    return int'((pc >> 2) % DEPTH);
  endfunction

  // driver: one cycle of stimulus plus its expected outputs
  task automatic step(input bit lv, input logic [PC_W-1:0] lp,
                      input bit uv, input logic [PC_W-1:0] up, input bit ut,
                      input string req);
    item_t it;
    @(negedge clk); #1;
    lk_valid = lv; lk_pc = lp; upd_valid = uv; upd_pc = up; upd_taken = ut;
    it.req    = req;
    it.exp_lk = lv && (model[slot(lp)] >= 2);
    it.exp_mp = uv && ((model[slot(up)] >= 2) != ut);
    sb.push_back(it);
    if (uv) begin
      if (ut && model[slot(up)] < 3) model[slot(up)]++;
      if (!ut && model[slot(up)] > 0) model[slot(up)]--;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    step(1, pc, 0, 16'h0, 0, req);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input bit t, input string req);
    step(0, 16'h0, 1, pc, t, req);
  endtask

  // monitor: compare late in the cycle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk); #3;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (lk_taken !== it.exp_lk) begin
          errors++;
          $display("FAIL %s lk_taken actual=%0b expected=%0b", it.req, lk_taken, it.exp_lk);
        end
        checks++;
        if (upd_mispredict !== it.exp_mp) begin
          errors++;
          $display("FAIL %s upd_mispredict actual=%0b expected=%0b", it.req, upd_mispredict, it.exp_mp);
        end
        checks++;
        if (lk_ready !== 1'b1 || upd_ready !== 1'b1) begin
          errors++;
          $display("FAIL R8 ready actual=%0b%0b expected=11", lk_ready, upd_ready);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: idle ports
    step(0, 16'h4, 0, 16'h4, 1, "R8");
    // R1/R3: every slot weakly not-taken after reset
    for (int i = 0; i < DEPTH; i++) look(PC_W'(i * 4), "R1");
    upd(16'h0000, 1, "R1");
    look(16'h0000, "R1");
    // R4: climb and saturate at strongly taken
    upd(16'h0000, 1, "R4");
    upd(16'h0000, 1, "R4");
    upd(16'h0000, 1, "R4");
    look(16'h0000, "R4");
    // R10: a single not-taken from 11 keeps taken
    upd(16'h0000, 0, "R10");
    look(16'h0000, "R10");
    upd(16'h0000, 0, "R3");
    look(16'h0000, "R3");
    // R5: descend and saturate at strongly not-taken
    upd(16'h0004, 0, "R5");
    upd(16'h0004, 0, "R5");
    upd(16'h0004, 0, "R5");
    look(16'h0004, "R5");
    upd(16'h0004, 1, "R5");
    look(16'h0004, "R5");
    // R2: aliasing and independence
    upd(16'h0008, 1, "R2");
    look(16'h000B, "R2");
    look(16'h0028, "R2");
    look(16'h000C, "R2");
    upd(16'h0120, 1, "R2");
    look(16'h0000, "R2");
    // R6: same-slot lookup and update in one cycle
    upd(16'h0010, 1, "R6");
    step(1, 16'h0010, 1, 16'h0010, 0, "R6");
    step(1, 16'h0030, 1, 16'h0010, 1, "R6");
    look(16'h0010, "R6");
    // R9: invalid update does not change state
    step(0, 16'h0, 0, 16'h0014, 1, "R9");
    step(0, 16'h0, 0, 16'h0014, 1, "R9");
    look(16'h0014, "R9");
    // R7/R10: loop branch, exit then re-entry
    for (int k = 0; k < 2; k++) begin
      for (int j = 0; j < 4; j++) step(1, 16'h0018, 1, 16'h0018, 1, "R10");
      step(1, 16'h0018, 1, 16'h0018, 0, "R7");
    end
    look(16'h0018, "R10");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule